// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block frees a downstream two-wire bus that a slave may be holding mid-transfer. After one `start` pulse it clocks nine pulses onto the clock line and keeps the data line released the whole time. To the slave this looks like eight data bits followed by a not-acknowledge, so a slave that was transmitting lets go of the data line. The block then places a STOP condition on the bus, which closes any read that was left half-finished. The sequence always runs in full. It does not look at the bus lines, so it behaves the same whether the bus was idle or busy.

The two outputs are drive-low enables for open-drain pads. A value of 1 pulls the line low, and a value of 0 releases it to its pull-up. The pace comes from a clock-enable `tick`. Each low half and each high half of the bus clock lasts `half_len` ticks. With a 1 MHz tick, `half_len = 5` gives roughly 100 kHz. The value of `half_len` is captured when the sequence starts. When the last step completes, `done` pulses for one cycle. Connecting the bus to a master, raising interrupts and clock stretching are handled elsewhere.

Top module: `bus_recovery_seq`

## Requirements
- R1: After reset, and whenever reset is asserted, `scl_low` and `sda_low` are both 0 (both lines released) and `done` is 0.
- R2: A `start` pulse while the block is idle makes `scl_low` go to 1 in the next cycle. Exactly nine release edges of SCL (`scl_low` 1 to 0) then follow while `sda_low` stays 0.
- R3: `sda_low` remains 0 from the start until the ninth SCL high half has finished.
- R4: Each SCL low half and high half of the burst lasts L ticks, where L = `half_len` (a value of 0 counts as 1). L is captured at the start, and a change to `half_len` while the sequence runs has no effect. Cycles without `tick` do not advance the sequence.
- R5: After the ninth high half, the STOP proceeds in this order: SCL is pulled low; L ticks later SDA is pulled low while SCL stays low; L ticks later SCL is released while SDA stays low; L ticks later SDA is released while SCL is high.
- R6: `done` is 1 for exactly one cycle, which is the cycle in which SDA is released at the end of the STOP. With a tick in every cycle, `done` appears 21·L cycles after the first cycle in which `scl_low` is 1.
- R7: A `start` pulse while the sequence is running is ignored. The pulse count, the phase lengths and the time of `done` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Clock enable that sets the time base of each half period |
| start | input | 1 | One-cycle request to run the recovery sequence |
| half_len | input | LEN_W | Length of a bus clock half period, in ticks (0 is taken as 1) |
| scl_low | output | 1 | 1 pulls the downstream clock line low |
| sda_low | output | 1 | 1 pulls the downstream data line low |
| done | output | 1 | One-cycle pulse when the STOP is complete |

## Verification
A wrong phase state or a wrong tick count shows on the ports within one half period. It appears as an SCL low or high run of the wrong length, or as an SDA edge that comes while SCL is in the wrong level. A pulse counter that is off by one moves the STOP by a whole bus clock period. This changes the number of SCL release edges seen with SDA released, and it moves `done` by 2·L ticks. The bench measures every run length and every edge order over a sweep of half-period lengths and tick spacings, so each of these faults is caught in the phase where it arises.

// File: rtl/brs_pkg.sv
// Shared types for the bus recovery sequencer.
// Assumes: only the sequencer modules use these types.
package brs_pkg;

    // Phases of the recovery sequence, in the order they occur
    typedef enum logic [2:0] {
        PH_IDLE     = 3'd0,
        PH_BURST_LO = 3'd1,
        PH_BURST_HI = 3'd2,
        PH_STOP_PRE = 3'd3,
        PH_STOP_SDA = 3'd4,
        PH_STOP_SCL = 3'd5
    } brs_phase_e;

endpackage

// File: rtl/brs_phase_timer.sv
// Half-period timer. It counts ticks while the sequence runs and flags the
// last tick of each phase.
// Assumes: load is raised for one cycle when a sequence is accepted, before run goes high.
module brs_phase_timer #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] len_in,
    input  logic             run,
    input  logic             tick,
    output logic             phase_end
);
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] cnt_q;
    logic             at_last;

    // Capture the phase length at start, taking 0 as 1
    always_ff @(posedge clk) begin
        if (!rst_n)
            len_q <= LEN_W'(1);
        else if (load)
            len_q <= (len_in == '0) ? LEN_W'(1) : len_in;
    end

    assign at_last = (cnt_q == len_q - LEN_W'(1));

    // Count ticks within the current phase, wrapping at the phase end
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= at_last ? '0 : cnt_q + LEN_W'(1);
    end

    assign phase_end = run && tick && at_last;
endmodule

// File: rtl/brs_pulse_counter.sv
// Counts the completed SCL high halves of the burst and flags the final one.
// Assumes: clear and inc never occur in the same cycle.
module brs_pulse_counter #(
    parameter int PULSES = 9,
    localparam int PW    = $clog2(PULSES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          inc,
    output logic          last,
    output logic [PW-1:0] count
);
    // Track the number of completed clock pulses
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            count <= '0;
        else if (inc)
            count <= count + PW'(1);
    end

    assign last = (count == PW'(PULSES - 1));
endmodule

// File: rtl/brs_ctrl.sv
// Phase sequencer. It steps through the burst and the STOP and drives
// registered drive-low enables and the done pulse.
// Assumes: phase_end comes from the timer and last from the pulse counter.
module brs_ctrl
    import brs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic phase_end,
    input  logic last,
    output logic busy,
    output logic load,
    output logic clear,
    output logic inc,
    output logic scl_low,
    output logic sda_low,
    output logic done
);
    brs_phase_e state_q, state_d;
    logic       done_d;

    // Next phase and the strobes to timer and counter
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        clear   = 1'b0;
        inc     = 1'b0;
        done_d  = 1'b0;
        unique case (state_q)
            PH_IDLE: begin
                if (start) begin
                    load    = 1'b1;
                    clear   = 1'b1;
                    state_d = PH_BURST_LO;
                end
            end
            PH_BURST_LO: if (phase_end) state_d = PH_BURST_HI;
            PH_BURST_HI: begin
                if (phase_end) begin
                    inc     = 1'b1;
                    state_d = last ? PH_STOP_PRE : PH_BURST_LO;
                end
            end
            PH_STOP_PRE: if (phase_end) state_d = PH_STOP_SDA;
            PH_STOP_SDA: if (phase_end) state_d = PH_STOP_SCL;
            PH_STOP_SCL: begin
                if (phase_end) begin
                    done_d  = 1'b1;
                    state_d = PH_IDLE;
                end
            end
            default: state_d = PH_IDLE;
        endcase
    end

    // Phase register and registered pad enables decoded from the next phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            scl_low <= 1'b0;
            sda_low <= 1'b0;
            done    <= 1'b0;
        end else begin
            state_q <= state_d;
            scl_low <= (state_d == PH_BURST_LO) || (state_d == PH_STOP_PRE)
                    || (state_d == PH_STOP_SDA);
            sda_low <= (state_d == PH_STOP_SDA) || (state_d == PH_STOP_SCL);
            done    <= done_d;
        end
    end

    assign busy = (state_q != PH_IDLE);
endmodule

// File: rtl/bus_recovery_seq.sv
// Two-wire bus recovery sequencer top. It sends nine clock pulses with SDA
// released and then a STOP, paced by tick.
// Assumes: the pads are open-drain with pull-ups, and tick is synchronous to clk.
module bus_recovery_seq #(
    parameter int LEN_W  = 16,
    parameter int PULSES = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic [LEN_W-1:0] half_len,
    output logic             scl_low,
    output logic             sda_low,
    output logic             done
);
    localparam int PW = $clog2(PULSES + 1);

    logic          busy, load, clear, inc, phase_end, last;
    logic [PW-1:0] pulse_cnt;

    brs_phase_timer #(.LEN_W(LEN_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(load), .len_in(half_len),
        .run(busy), .tick(tick), .phase_end(phase_end)
    );

    brs_pulse_counter #(.PULSES(PULSES)) u_pulses (
        .clk(clk), .rst_n(rst_n), .clear(clear), .inc(inc),
        .last(last), .count(pulse_cnt)
    );

    brs_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .phase_end(phase_end),
        .last(last), .busy(busy), .load(load), .clear(clear), .inc(inc),
        .scl_low(scl_low), .sda_low(sda_low), .done(done)
    );
endmodule

// File: rtl/brs_checker.sv
// Property checker for the recovery sequencer, bound to the top module.
// Assumes: it sees the top's ports plus the busy flag and pulse count.
module brs_checker #(
    parameter int PULSES = 9,
    localparam int PW    = $clog2(PULSES + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          scl_low,
    input logic          sda_low,
    input logic          done,
    input logic          busy,
    input logic [PW-1:0] pulse_cnt
);
    // R1: reset releases both lines and clears done
    p_reset_release_r1: assert property (@(posedge clk)
        !rst_n |=> (!scl_low && !sda_low && !done));

    // R2: the pulse count never passes the burst length
    p_pulse_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_cnt <= PW'(PULSES));

    // R3: SDA is pulled only after the full burst
    p_sda_after_burst_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_low) |-> (pulse_cnt == PW'(PULSES)));

    // R4: without a tick a running sequence holds both lines
    p_hold_without_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> ($stable(scl_low) && $stable(sda_low) && !done));

    // R5: SDA is pulled only while SCL is low
    p_sda_pull_scl_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_low) |-> scl_low);

    // R5: SDA is released (STOP) only while SCL is high
    p_stop_scl_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_low) |-> !scl_low);

    // R6: done lasts a single cycle
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: done coincides with both lines released
    p_done_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!scl_low && !sda_low && !busy));
endmodule

bind bus_recovery_seq brs_checker #(.PULSES(PULSES)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .scl_low(scl_low),
    .sda_low(sda_low), .done(done), .busy(busy), .pulse_cnt(pulse_cnt)
);

// File: tb/bus_recovery_seq_tb.sv
module bus_recovery_seq_tb;
    localparam int LEN_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [LEN_W-1:0] half_len = '0;
    logic             scl_low, sda_low, done;
    logic             tick;
    int               tick_per = 1;
    int               tcnt = 0;
    int               n_tests = 0;
    int               n_fail = 0;

    always #5 clk = ~clk;

    // Tick generator: one tick every tick_per cycles, updated away from the active edge
    always @(negedge clk) tcnt <= (tcnt >= tick_per - 1) ? 0 : tcnt + 1;
    assign tick = (tcnt == 0);

    bus_recovery_seq #(.LEN_W(LEN_W), .PULSES(9)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
        .half_len(half_len), .scl_low(scl_low), .sda_low(sda_low), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Run one sequence and measure it at the ports. inj > 0 injects a start
    // pulse and a half_len change at that sample.
    task automatic run_seq(input int hl, input int per, input int inj);
        int L, LP, c, run_len, idx, pulses, stop_rel, sda_pulls, dones, done_at;
        bit p_scl, p_sda, finished;
        L  = (hl == 0) ? 1 : hl;
        LP = L * per;
        tick_per = per;
        half_len = LEN_W'(hl);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(scl_low && !sda_low, "R2 scl pulled after start", int'(scl_low), 1);
        p_scl = 1'b1; p_sda = 1'b0; run_len = 1; idx = 0; c = 1;
        pulses = 0; stop_rel = 0; sda_pulls = 0; dones = 0; done_at = 0;
        finished = 1'b0;
        while (!finished) begin
            @(negedge clk);
            c++;
            if (inj > 0 && c == inj) begin
                start = 1'b1;
                half_len = LEN_W'(hl + 7);
            end else if (inj > 0 && c == inj + 1) begin
                start = 1'b0;
            end
            if (scl_low != p_scl) begin
                if (idx < 18 && (per == 1 || idx > 0))
                    check(run_len == LP, "R4 burst half length", run_len, LP);
                if (idx == 18)
                    check(run_len == 2 * LP, "R5 stop low stretch", run_len, 2 * LP);
                if (!scl_low) begin
                    if (sda_low) stop_rel++;
                    else pulses++;
                end
                idx++;
                run_len = 1;
            end else begin
                run_len++;
            end
            if (sda_low && !p_sda) begin
                sda_pulls++;
                check(pulses == 9, "R3 sda held until burst ends", pulses, 9);
                check(scl_low, "R5 sda pulled while scl low", int'(scl_low), 1);
                check(run_len == LP + 1, "R5 sda pull delay", run_len, LP + 1);
            end
            if (!sda_low && p_sda) begin
                check(!scl_low, "R5 stop with scl high", int'(scl_low), 0);
                check(run_len == LP + 1, "R5 stop delay", run_len, LP + 1);
                check(done, "R6 done with sda release", int'(done), 1);
            end
            if (done) begin
                dones++;
                if (done_at == 0) done_at = c;
            end
            p_scl = scl_low;
            p_sda = sda_low;
            if (done_at != 0 && c >= done_at + 4) finished = 1'b1;
            if (c > 21 * LP + 60) begin
                check(1'b0, "R6 watchdog done never seen", c, 21 * LP);
                finished = 1'b1;
            end
        end
        check(pulses == 9, inj > 0 ? "R7 pulses with extra start" : "R2 pulse count", pulses, 9);
        check(stop_rel == 1, "R5 scl released during stop", stop_rel, 1);
        check(sda_pulls == 1, "R3 single sda pull", sda_pulls, 1);
        check(dones == 1, "R6 done single cycle", dones, 1);
        if (per == 1)
            check(done_at == 21 * L + 1, inj > 0 ? "R7 done time with extra start" : "R6 done time",
                  done_at, 21 * L + 1);
        check(!scl_low && !sda_low, "R6 lines idle after done", int'(scl_low) + int'(sda_low), 0);
    endtask

    int hl_set[5] = '{0, 1, 2, 3, 5};

    initial begin
        repeat (3) @(negedge clk);
        check(!scl_low && !sda_low && !done, "R1 reset state", int'(scl_low) + int'(sda_low), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!scl_low && !sda_low && !done, "R1 idle after reset", int'(scl_low) + int'(sda_low), 0);
        for (int p = 1; p <= 3; p++)
            for (int i = 0; i < 5; i++)
                run_seq(hl_set[i], p, 0);
        run_seq(3, 1, 10);
        run_seq(2, 1, 30);
        run_seq(4, 2, 50);
        // Reset in the middle of a sequence
        tick_per = 1;
        half_len = LEN_W'(4);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (75) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!scl_low && !sda_low && !done, "R1 mid-run reset releases", int'(scl_low) + int'(sda_low), 0);
        rst_n = 1'b1;
        run_seq(2, 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog for a hung run
    initial begin
        #1500000;
        n_tests++;
        n_fail++;
        $display("FAIL R6 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule